// File: doc/BRIEF.md
# Addressable Latch with Demultiplex Mode

This block is a small bit-addressable register. A binary select input picks one bit of a parallel output word, and a single serial data input supplies the value for that bit. Two control inputs choose what happens on each rising clock edge. `wr_en_n` is an active-low enable and `zap` is an active-high clear. Together they give four modes: write the selected bit, hold everything, steer the data bit onto the selected output while all other outputs go low, or clear the whole word.

The latch behaviour is modelled as a clocked design. The register takes its new value on each rising edge of `clk`, based on the mode and inputs present just before that edge. A synchronous reset, separate from `zap`, zeroes the word. The select must only change while the block is in hold mode. A host can build any parallel word by stepping the select through every address in write mode.

Top module: `addr_latch_demux`

## Requirements
- R1: A rising edge with `rst` high makes every bit of `q` 0 after that edge, whatever the other inputs are.
- R2: Write mode (`wr_en_n`=0, `zap`=0): after the edge, bit `q[sel]` equals `din`, and every other bit keeps its value.
- R3: Hold mode (`wr_en_n`=1, `zap`=0): `q` is unchanged across the edge for any `din` and `sel`.
- R4: Demultiplex mode (`wr_en_n`=0, `zap`=1): after the edge, `q[sel]` equals `din` and every other bit is 0, so `q` is either one-hot at position `sel` or all zero.
- R5: Clear mode (`wr_en_n`=1, `zap`=1): after the edge, every bit of `q` is 0, whatever `din` and `sel` are.
- R6: The pattern left by demultiplex mode stays in the register, so a following hold mode keeps showing that one-hot or all-zero word.
- R7: Stepping `sel` through 0 to NUM_BITS-1 in write mode, with bit k of a word presented on `din` at address k, leaves `q` equal to that word, whatever `q` held before.
- R8: `q` changes only on a rising clock edge and only through the four modes or the reset; bit i of `q` corresponds to `sel` value i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, clears all bits |
| wr_en_n | input | 1 | Active-low enable; low lets data in |
| zap | input | 1 | Active-high clear / demultiplex select |
| din | input | 1 | Serial data bit |
| sel | input | ADDR_W | Binary address of the target bit |
| q | output | 2**ADDR_W | Registered parallel outputs |

## Verification
The bench builds the block with the default ADDR_W of 3, so `q` has eight outputs. This makes the top address 7 and the full eight-step serial load reachable. It also makes a demultiplex pulse at each end of the word observable. With only three select bits, every address can be visited in each mode, and several distinct byte patterns, including all-ones, all-zeros and alternating bits, can be pushed through the serial load in a few hundred cycles.

// File: rtl/alm_pkg.sv
package alm_pkg;

   typedef enum logic [1:0] {
      MODE_WRITE = 2'd0,
      MODE_HOLD  = 2'd1,
      MODE_DEMUX = 2'd2,
      MODE_CLEAR = 2'd3
   } alm_mode_e;

   function automatic alm_mode_e decode_mode(input logic en_n, input logic clr);
      alm_mode_e m;
      unique case ({en_n, clr})
         2'b00:   m = MODE_WRITE;
         2'b10:   m = MODE_HOLD;
         2'b01:   m = MODE_DEMUX;
         default: m = MODE_CLEAR;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/alm_mode_decode.sv
module alm_mode_decode (
   input  logic                en_n,
   input  logic                clr,
   output alm_pkg::alm_mode_e  mode
);
   always_comb mode = alm_pkg::decode_mode(en_n, clr);
endmodule

// File: rtl/alm_addr_decode.sv
module alm_addr_decode #(
   parameter int ADDR_W = 3,
   localparam int NUM_BITS = 1 << ADDR_W
) (
   input  logic [ADDR_W-1:0]   sel,
   output logic [NUM_BITS-1:0] hit
);
   for (genvar i = 0; i < NUM_BITS; i++) begin : g_hit
      assign hit[i] = (sel == ADDR_W'(i));
   end
endmodule

// File: rtl/alm_bit_cell.sv
module alm_bit_cell (
   input  logic               clk,
   input  logic               rst,
   input  alm_pkg::alm_mode_e mode,
   input  logic               hit,
   input  logic               din,
   output logic               q_bit
);
   import alm_pkg::*;

   logic nxt;

   always_comb begin
      unique case (mode)
         MODE_WRITE: nxt = hit ? din : q_bit;
         MODE_HOLD:  nxt = q_bit;
         MODE_DEMUX: nxt = hit & din;
         default:    nxt = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) q_bit <= 1'b0;
      else     q_bit <= nxt;
   end
endmodule

// File: rtl/addr_latch_demux.sv
module addr_latch_demux #(
   parameter int ADDR_W = 3,
   localparam int NUM_BITS = 1 << ADDR_W
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                wr_en_n,
   input  logic                zap,
   input  logic                din,
   input  logic [ADDR_W-1:0]   sel,
   output logic [NUM_BITS-1:0] q
);
   if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_param
      $error("addr_latch_demux: ADDR_W must be within 1..8");
   end

   alm_pkg::alm_mode_e     mode;
   logic [NUM_BITS-1:0]    hit;

   alm_mode_decode u_mode (
      .en_n (wr_en_n),
      .clr  (zap),
      .mode (mode)
   );

   alm_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .sel (sel),
      .hit (hit)
   );

   for (genvar i = 0; i < NUM_BITS; i++) begin : g_cell
      alm_bit_cell u_cell (
         .clk   (clk),
         .rst   (rst),
         .mode  (mode),
         .hit   (hit[i]),
         .din   (din),
         .q_bit (q[i])
      );
   end
endmodule

// File: rtl/alm_checker.sv
module alm_checker #(
   parameter int ADDR_W = 3,
   localparam int NUM_BITS = 1 << ADDR_W
) (
   input logic                clk,
   input logic                rst,
   input logic                wr_en_n,
   input logic                zap,
   input logic                din,
   input logic [ADDR_W-1:0]   sel,
   input logic [NUM_BITS-1:0] q
);
   logic rst_d = 1'b0;
   always_ff @(posedge clk) rst_d <= rst;

   always_ff @(posedge clk) begin
      if (rst_d) AST_RESET_ZERO: assert (q == '0); // R1
   end

   AST_WRITE_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
      (!wr_en_n && !zap) |=> (q[$past(sel)] == $past(din)) &&
         (((q ^ $past(q)) & ~(NUM_BITS'(1) << $past(sel))) == '0)); // R2

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
      (wr_en_n && !zap) |=> $stable(q)); // R3

   AST_DEMUX_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      (!wr_en_n && zap) |=> $onehot0(q) &&
         (q == ($past(din) ? (NUM_BITS'(1) << $past(sel)) : '0))); // R4

   AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
      (wr_en_n && zap) |=> (q == '0)); // R5
endmodule

bind addr_latch_demux alm_checker #(.ADDR_W(ADDR_W)) u_alm_chk (.*);

// File: tb/tb_addr_latch_demux.sv
module tb_addr_latch_demux;
   localparam int AW = 3;
   localparam int NB = 1 << AW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_en_n = 1'b1;
   logic          zap = 1'b0;
   logic          din = 1'b0;
   logic [AW-1:0] sel = '0;
   logic [NB-1:0] q;

   int checks = 0;
   int errors = 0;
   logic [NB-1:0] exp_q = '0;

   always #5 clk = ~clk;

   addr_latch_demux #(.ADDR_W(AW)) dut (
      .clk(clk), .rst(rst), .wr_en_n(wr_en_n), .zap(zap),
      .din(din), .sel(sel), .q(q)
   );

   task automatic chk(input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: q=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // one clock: drive, take the edge, update the model, compare
   task automatic cyc(input logic e_n, input logic c, input logic [AW-1:0] a,
                      input logic d, input string req);
      wr_en_n = e_n; zap = c; sel = a; din = d;
      @(posedge clk); #1;
      unique case ({e_n, c})
         2'b00: exp_q[a] = d;
         2'b10: ;
         2'b01: exp_q = d ? (NB'(1) << a) : '0;
         default: exp_q = '0;
      endcase
      chk(req, q, exp_q);
   endtask

   task automatic t_reset();
      rst = 1'b1; wr_en_n = 1'b0; zap = 1'b0; din = 1'b1; sel = 3'd5;
      @(posedge clk); #1;
      exp_q = '0;
      chk("R1 reset", q, '0);
      rst = 1'b0; wr_en_n = 1'b1;
   endtask

   task automatic t_write();
      cyc(1'b0, 1'b0, 3'd0, 1'b1, "R2 write bit0");
      cyc(1'b0, 1'b0, 3'd7, 1'b1, "R2 write bit7");
      cyc(1'b0, 1'b0, 3'd3, 1'b1, "R2 write bit3");
      cyc(1'b0, 1'b0, 3'd0, 1'b0, "R2 clear bit0");
      chk("R2 R8 mapping", q, 8'b1000_1000);
   endtask

   task automatic t_hold();
      logic [NB-1:0] snap;
      snap = q;
      for (int i = 0; i < NB; i++) cyc(1'b1, 1'b0, AW'(i), i[0], "R3 hold");
      chk("R3 hold unchanged", q, snap);
   endtask

   task automatic t_demux();
      cyc(1'b0, 1'b0, 3'd2, 1'b1, "R2 preload");
      cyc(1'b0, 1'b1, 3'd6, 1'b1, "R4 demux one");
      chk("R4 onehot6", q, 8'b0100_0000);
      cyc(1'b0, 1'b1, 3'd0, 1'b1, "R4 demux bit0");
      cyc(1'b0, 1'b1, 3'd7, 1'b1, "R4 demux bit7");
      cyc(1'b1, 1'b0, 3'd1, 1'b0, "R6 hold after demux");
      cyc(1'b1, 1'b0, 3'd4, 1'b1, "R6 hold after demux");
      chk("R6 retained", q, 8'b1000_0000);
      cyc(1'b0, 1'b1, 3'd4, 1'b0, "R4 demux zero");
      chk("R4 zero", q, '0);
      cyc(1'b1, 1'b0, 3'd4, 1'b1, "R6 zero retained");
   endtask

   task automatic t_clear();
      cyc(1'b0, 1'b0, 3'd1, 1'b1, "R2 preload");
      cyc(1'b0, 1'b0, 3'd5, 1'b1, "R2 preload");
      cyc(1'b1, 1'b1, 3'd5, 1'b1, "R5 clear");
      chk("R5 all zero", q, '0);
   endtask

   task automatic t_serial(input logic [NB-1:0] pat);
      for (int a = 0; a < NB; a++) begin
         cyc(1'b1, 1'b0, AW'(a), pat[a], "R3 address set in hold");
         cyc(1'b0, 1'b0, AW'(a), pat[a], "R7 serial step");
      end
      cyc(1'b1, 1'b0, '0, 1'b0, "R7 hold");
      chk("R7 serial word", q, pat);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: q=%b expected=done", q);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      @(posedge clk); #1;
      t_reset();
      t_write();
      t_hold();
      t_demux();
      t_clear();
      t_serial(8'hA5);
      t_serial(8'hFF);
      t_serial(8'h00);
      t_serial(8'h5A);
      t_serial(8'h81);
      cyc(1'b0, 1'b0, 3'd3, 1'b1, "R2 preload");
      t_reset();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule